// File: doc/BRIEF.md
# Cartridge Bank Latch

This block is a small register device for the cartridge side of an 8-bit CPU bus. It decodes a handful of CPU address lines, a ROM-select strobe, the read/write line and the bus-phase clock. From these it maintains two mode flags, a 4-bit staging register, a 6-bit working register and a 5-bit bank latch. The latch outputs drive the upper address lines of the cartridge memories.

Software prepares a value in the working register. It does this either by stepping the register's low nibble or by copying the staging register through an optional inversion. A separate write anywhere in the ROM area then commits the working register to the bank outputs. The working register can be read back through a 5-bit data port. The invert flag also steers a two-input selector, and an OR output combines the selector with the top data bit.

The bus-phase clock is sampled by the system clock. A write is acted upon when a high-to-low transition of the bus phase is seen with R/W low. The data port is modelled as separate input, output and output-enable pins. Data lanes are numbered 4..0 for CPU data bits 5, 4, 2, 1 and 0.

Top module: `cart_bank_latch`

## Requirements
- R1: A synchronous active-high reset clears both mode flags, the staging register, the working register and the bank latch. After reset, bank_q reads 0 and a readback returns 0.
- R2: A register write (rom_sel_n=1, a14=1, a13=0, a8=1) with {a1,a0}=11 loads the increment flag from lane 0. With {a1,a0}=01 it loads the invert flag from lane 0.
- R3: A register write with {a1,a0}=10 loads working bits 5 and 4 from lanes 4 and 3, and staging bits 2..0 from lanes 2..0. Staging bit 3 is loaded from lane 0 only when the invert flag is set; otherwise it keeps its value.
- R4: A register write with {a1,a0}=00 and the increment flag set adds one to working bits 3..0, wrapping from 15 to 0. The data value is ignored.
- R5: A register write with {a1,a0}=00 and the increment flag clear loads working bits 3..0 from staging bits 3..0, each XORed with the invert flag.
- R6: While m2=1, rw=1, rom_sel_n=1, a14=1, a13=0 and a8=1, for any a1 and a0, data_oe is 1. In that case data_out is {W5^V, W4^V, W2, W1, W0}, where W is the working register and V is the invert flag. In every other case data_oe is 0.
- R7: Any write with rom_sel_n=0 sets bank_q[3:0] to working bits 3..0 and bank_q[4] to working bit 4 XOR the invert flag. bank_q changes on no other event.
- R8: sel_out equals sel_in1 when the invert flag is set and sel_in0 when it is clear. or_out equals sel_out OR the data-lane-4 pin value, which is data_out[4] when data_oe=1 and data_in[4] otherwise.
- R9: A bus cycle changes no state when it is a read (rw=1), or when it is a write that matches neither the register decode nor rom_sel_n=0. Each write acts exactly once per falling m2 edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| m2 | input | 1 | CPU bus-phase clock, asynchronous to clk |
| rw | input | 1 | CPU read (1) / write (0) |
| rom_sel_n | input | 1 | Active-low ROM-area select |
| cpu_a14 | input | 1 | CPU address bit 14 |
| cpu_a13 | input | 1 | CPU address bit 13 |
| cpu_a8 | input | 1 | CPU address bit 8 |
| cpu_a1 | input | 1 | CPU address bit 1 |
| cpu_a0 | input | 1 | CPU address bit 0 |
| data_in | input | 5 | Data lanes in (CPU bits 5,4,2,1,0) |
| data_out | output | 5 | Readback data lanes out |
| data_oe | output | 1 | Output enable for data_out |
| sel_in0 | input | 1 | Selector input chosen when invert flag is clear |
| sel_in1 | input | 1 | Selector input chosen when invert flag is set |
| sel_out | output | 1 | Selector result |
| or_out | output | 1 | sel_out OR data lane 4 pin value |
| bank_q | output | 5 | Committed bank outputs |

## Verification
The hardest states to reach are the interactions between the flags. Examples are a staging bit 3 that must survive a load made with the invert flag clear, an increment that wraps from 15, and a commit or readback taken while the invert flag is set. The working register is reached only through readback and commit, so each of these needs a multi-write sequence. Directed sequences set up each interaction explicitly. A long seeded random run of mixed register writes, commits, reads and stray addresses then covers the remaining orderings against a bench model.

// File: rtl/cbl_pkg.sv
package cbl_pkg;
  localparam int LANES  = 5;
  localparam int WORK_W = 6;
  localparam int STAGE_W = 4;
  localparam int BANK_W = 5;
  localparam int NREGS  = 4;

  typedef enum logic [1:0] {
    SEL_RUN  = 2'd0,
    SEL_INV  = 2'd1,
    SEL_LOAD = 2'd2,
    SEL_INC  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/cbl_m2_sync.sv
module cbl_m2_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic m2_async,
  output logic m2_fall
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], m2_async};
  end

  assign m2_fall = chain[STAGES] & ~chain[STAGES-1];

  // R9
  single_fall_chk: assert property (@(posedge clk) disable iff (rst)
    m2_fall |=> !m2_fall);
endmodule

// File: rtl/cbl_decode.sv
module cbl_decode
  import cbl_pkg::*;
(
  input  logic             m2_fall,
  input  logic             rw,
  input  logic             rom_sel_n,
  input  logic             cpu_a14,
  input  logic             cpu_a13,
  input  logic             cpu_a8,
  input  logic             cpu_a1,
  input  logic             cpu_a0,
  output logic [NREGS-1:0] reg_we,
  output logic             commit,
  output logic             rd_hit
);
  logic page_hit;
  logic wr_ev;

  assign page_hit = rom_sel_n & cpu_a14 & ~cpu_a13 & cpu_a8;
  assign wr_ev    = m2_fall & ~rw;
  assign rd_hit   = page_hit;
  assign commit   = wr_ev & ~rom_sel_n;

  for (genvar i = 0; i < NREGS; i++) begin : g_sel
    assign reg_we[i] = wr_ev & page_hit & ({cpu_a1, cpu_a0} == 2'(i));
  end
endmodule

// File: rtl/cbl_core.sv
module cbl_core
  import cbl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [NREGS-1:0] reg_we,
  input  logic             commit,
  input  logic [LANES-1:0] wdata,
  output logic [LANES-1:0] rdata,
  output logic [BANK_W-1:0] q,
  output logic             inv
);
  logic               c;
  logic               v;
  logic [STAGE_W-1:0] p;
  logic [WORK_W-1:0]  r;

  always_ff @(posedge clk) begin
    if (rst) begin
      c <= 1'b0;
      v <= 1'b0;
      p <= '0;
      r <= '0;
      q <= '0;
    end else begin
      if (reg_we[SEL_INC]) c <= wdata[0];
      if (reg_we[SEL_INV]) v <= wdata[0];
      if (reg_we[SEL_LOAD]) begin
        r[5:4] <= wdata[4:3];
        p[2:0] <= wdata[2:0];
        if (v) p[3] <= wdata[0];
      end
      if (reg_we[SEL_RUN]) begin
        if (c) r[3:0] <= r[3:0] + 4'd1;
        else   r[3:0] <= p ^ {STAGE_W{v}};
      end
      if (commit) q <= {r[4] ^ v, r[3:0]};
    end
  end

  assign rdata = {r[5] ^ v, r[4] ^ v, r[2:0]};
  assign inv   = v;

  // R4
  inc_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_we[SEL_RUN] && c) |=> (r[3:0] == $past(r[3:0]) + 4'd1));
  // R7
  bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(q));
  // R2
  inv_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_we[SEL_INV] |=> $stable(v));
  // R3
  stage_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_we[SEL_LOAD] |=> $stable(p));
endmodule

// File: rtl/cart_bank_latch.sv
module cart_bank_latch
  import cbl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              m2,
  input  logic              rw,
  input  logic              rom_sel_n,
  input  logic              cpu_a14,
  input  logic              cpu_a13,
  input  logic              cpu_a8,
  input  logic              cpu_a1,
  input  logic              cpu_a0,
  input  logic [LANES-1:0]  data_in,
  output logic [LANES-1:0]  data_out,
  output logic              data_oe,
  input  logic              sel_in0,
  input  logic              sel_in1,
  output logic              sel_out,
  output logic              or_out,
  output logic [BANK_W-1:0] bank_q
);
  logic             m2_fall;
  logic [NREGS-1:0] reg_we;
  logic             commit;
  logic             rd_hit;
  logic             inv;
  logic             lane4_pin;

  cbl_m2_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .m2_async(m2), .m2_fall(m2_fall)
  );

  cbl_decode u_dec (
    .m2_fall(m2_fall), .rw(rw), .rom_sel_n(rom_sel_n),
    .cpu_a14(cpu_a14), .cpu_a13(cpu_a13), .cpu_a8(cpu_a8),
    .cpu_a1(cpu_a1), .cpu_a0(cpu_a0),
    .reg_we(reg_we), .commit(commit), .rd_hit(rd_hit)
  );

  cbl_core u_core (
    .clk(clk), .rst(rst), .reg_we(reg_we), .commit(commit),
    .wdata(data_in), .rdata(data_out), .q(bank_q), .inv(inv)
  );

  assign data_oe   = m2 & rw & rd_hit;
  assign sel_out   = inv ? sel_in1 : sel_in0;
  assign lane4_pin = data_oe ? data_out[4] : data_in[4];
  assign or_out    = sel_out | lane4_pin;
endmodule

// File: tb/cart_bank_latch_bench.sv
module cart_bank_latch_bench;
  logic clk = 0, rst = 1, m2 = 0, rw = 1, rom_sel_n = 1;
  logic a14 = 0, a13 = 0, a8 = 0, a1 = 0, a0 = 0;
  logic [4:0] din = 0;
  logic [4:0] dout, bq;
  logic doe, s0 = 0, s1 = 0, sout, oout;
  int vecs = 0, bad = 0, cyc = 0;

  // bench model state
  logic mc, mv;
  logic [3:0] mp;
  logic [5:0] mr;
  logic [4:0] mq;

  always #5 clk = ~clk;

  cart_bank_latch u_cart_bank_latch (
    .clk(clk), .rst(rst), .m2(m2), .rw(rw), .rom_sel_n(rom_sel_n),
    .cpu_a14(a14), .cpu_a13(a13), .cpu_a8(a8), .cpu_a1(a1), .cpu_a0(a0),
    .data_in(din), .data_out(dout), .data_oe(doe),
    .sel_in0(s0), .sel_in1(s1), .sel_out(sout), .or_out(oout), .bank_q(bq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_read();
    return {mr[5] ^ mv, mr[4] ^ mv, mr[2:0]};
  endfunction

  task automatic model_write(input logic rs_n, input logic [2:0] ahi,
                             input logic [1:0] alo, input logic [4:0] d);
    if (!rs_n) mq = {mr[4] ^ mv, mr[3:0]};
    else if (ahi == 3'b101) begin
      case (alo)
        2'b11: mc = d[0];
        2'b01: mv = d[0];
        2'b10: begin mr[5:4] = d[4:3]; mp[2:0] = d[2:0]; if (mv) mp[3] = d[0]; end
        default: if (mc) mr[3:0] = mr[3:0] + 4'd1; else mr[3:0] = mp ^ {4{mv}};
      endcase
    end
  endtask

  task automatic bus(input logic rw_i, input logic rs_n, input logic [2:0] ahi,
                     input logic [1:0] alo, input logic [4:0] d);
    @(negedge clk);
    rw = rw_i; rom_sel_n = rs_n; {a14, a13, a8} = ahi; {a1, a0} = alo; din = d;
    m2 = 1;
    repeat (4) @(negedge clk);
    if (rw_i) begin
      if (rs_n && ahi == 3'b101) begin
        chk("R6 oe", {7'd0, doe}, 8'd1);
        chk("R6 data", {3'd0, dout}, {3'd0, exp_read()});
      end else chk("R6 oe idle", {7'd0, doe}, 8'd0);
    end else chk("R6 oe write", {7'd0, doe}, 8'd0);
    m2 = 0;
    repeat (5) @(negedge clk);
    if (!rw_i) model_write(rs_n, ahi, alo, d);
    chk("R7/R9 bank", {3'd0, bq}, {3'd0, mq});
    chk("R6 oe low m2", {7'd0, doe}, 8'd0);
    chk("R8 sel", {6'd0, sout, oout}, {6'd0, (mv ? s1 : s0), (mv ? s1 : s0) | din[4]});
  endtask

  task automatic wreg(input logic [1:0] alo, input logic [4:0] d);
    bus(0, 1, 3'b101, alo, d);
  endtask
  task automatic commit_w(); bus(0, 0, 3'b000, 2'b00, 5'd0); endtask
  task automatic rd(); bus(1, 1, 3'b101, 2'b00, 5'd0); endtask

  initial begin
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    mc = 0; mv = 0; mp = 0; mr = 0; mq = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 bank", {3'd0, bq}, 8'd0);
    rd();
    // R3 staging bit 3 kept with invert clear: set P3 via invert, clear invert, reload
    wreg(2'b01, 5'd1);           // R2 V=1
    wreg(2'b10, 5'b11001);       // R3 P=1001 (bit3 loaded), R5:4=11
    rd();                        // R6 inverted readback
    wreg(2'b01, 5'd0);           // V=0
    wreg(2'b10, 5'b00110);       // P[2:0]=110, P3 kept 1
    wreg(2'b00, 5'b11111);       // R5 load R[3:0]=P=1110, data ignored
    commit_w();                  // R7
    // R4 increment wrap
    wreg(2'b11, 5'd1);           // R2 C=1
    wreg(2'b00, 5'd0);           // 1111
    wreg(2'b00, 5'd0);           // wraps to 0000
    commit_w();
    // R9 ignored: read at register page, write with a8=0
    bus(1, 1, 3'b101, 2'b01, 5'd0);
    bus(0, 1, 3'b100, 2'b00, 5'd0);
    bus(0, 1, 3'b111, 2'b11, 5'd0);
    commit_w();
    // R5 with invert set
    wreg(2'b11, 5'd0);
    wreg(2'b01, 5'd1);
    wreg(2'b00, 5'd0);
    commit_w();
    rd();
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic rwi, rsn; logic [2:0] ahi; logic [1:0] alo; logic [4:0] d;
      rwi = ($urandom % 10) < 3;
      rsn = ($urandom % 4) != 0;
      ahi = (($urandom % 10) < 7) ? 3'b101 : 3'($urandom);
      alo = 2'($urandom);
      d   = 5'($urandom);
      s0  = 1'($urandom);
      s1  = 1'($urandom);
      bus(rwi, rsn, ahi, alo, d);
    end
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule